// File: doc/BRIEF.md
# Reversible Parity-Checked Add/Subtract Cell

This block is a one-bit arithmetic cell. It performs either a full addition or a full subtraction of two operand bits and an incoming carry or borrow. A single mode pin picks the operation. It is built only from two reversible primitives: a five-in/five-out parity-preserving gate and a three-line controlled swap. Every output of both primitives leaves the cell, either as a result or as a garbage bit. Nothing is dropped, so the cell stays reversible as a whole.

The cell has no clock and no storage. Operand bits go into the reversible gate with one constant input tied low and a second constant chosen by a parameter. From that single pass the gate produces the sum, the carry and the borrow together. The controlled swap then routes either the carry or the borrow to the carry/borrow pin, as the mode pin selects. Because both primitives conserve parity, the xor of every primitive input must equal the xor of every primitive output. A monitor compares the two and raises a fault flag on any mismatch. Cells are chained through the carry/borrow pin to build wider add/subtract paths.

The cell has no data stream, so none of its pins carries a valid/ready handshake.

Top module: `rev_addsub_cell`

## Requirements
- R1: With `mode_sub` = 0, `cb_o` equals the full-add carry, ((a xor b) and cin) xor (a and b).
- R2: With `mode_sub` = 1, `cb_o` equals the full-subtract borrow of a − b − cin, ((not a) and b) xor ((not (a xor b)) and cin).
- R3: `res_o` equals a xor b xor cin in both modes.
- R4: The five-bit gate maps its 32 input vectors one-to-one onto 32 output vectors. Vectors are written first-input-first, as bit 4 down to bit 0. The first output always equals the first input, and input 00010 yields output 01011.
- R5: For every input vector of the five-bit gate, the xor of its five inputs equals the xor of its five outputs.
- R6: When the gate's second input is 1 and its fourth input is 0, its second output equals NOR of its first and third inputs.
- R7: `fault_o` is 0 for every combination of inputs and mode on a fault-free cell.
- R8: The garbage bits are laid out as follows:
  - `garbage_o[3]` is the swap's control pass-through and equals `mode_sub`.
  - `garbage_o[2]` is the swap's other output: the borrow in add mode and the carry in subtract mode.
  - `garbage_o[1]` equals `b_in`.
  - `garbage_o[0]` equals `c_in` xor the constant `ANCILLA_E`.
- R9: The value of the free constant `ANCILLA_E` (0 or 1) has no effect on `res_o`, `cb_o` or `fault_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_sub | input | 1 | 0 selects addition, 1 selects subtraction |
| a_in | input | 1 | First operand bit (minuend in subtract mode) |
| b_in | input | 1 | Second operand bit (subtrahend in subtract mode) |
| c_in | input | 1 | Incoming carry or borrow |
| res_o | output | 1 | Sum or difference bit |
| cb_o | output | 1 | Outgoing carry (add) or borrow (subtract) |
| garbage_o | output | 4 | Unused reversible outputs, layout per R8 |
| fault_o | output | 1 | High when primitive input parity differs from output parity |

## Verification
The bench drives all 32 vectors into the five-bit gate on its own. It compares each output against an independent column table and tracks which outputs have been seen, so a gate with a wrong minterm fails in two ways: it breaks the one-to-one mapping and it breaks parity. A cell that routes the carry and borrow the wrong way round is caught on operand sets where the two differ, such as 0 − 1 with no borrow in. A cell that takes its borrow from b − a instead of a − b is caught the same way. A second instance with the free constant set to 1 exposes any design whose arithmetic results depend on that constant.

// File: rtl/rev_cell_pkg.sv
package rev_cell_pkg;
  localparam int GATE_W = 5;
  localparam int SWAP_W = 3;
  localparam int GARB_W = 4;

  typedef logic [GATE_W-1:0] gate_vec_t;
  typedef logic [SWAP_W-1:0] swap_vec_t;

  // Bit positions of the gate lines, first line at the top
  localparam int L_FIRST  = GATE_W - 1;
  localparam int L_SECOND = GATE_W - 2;
  localparam int L_THIRD  = GATE_W - 3;
  localparam int L_FOURTH = GATE_W - 4;
  localparam int L_FIFTH  = GATE_W - 5;
endpackage

// File: rtl/pp5_gate.sv
module pp5_gate
  import rev_cell_pkg::*;
(
  input  gate_vec_t x_i,
  output gate_vec_t y_o
);
  logic a, b, c, d, e;
  logic p, q, r, s, t;

  always_comb begin
    a = x_i[L_FIRST];
    b = x_i[L_SECOND];
    c = x_i[L_THIRD];
    d = x_i[L_FOURTH];
    e = x_i[L_FIFTH];
    p = a;
    q = 1'b0;
    r = 1'b0;
    s = 1'b0;
    unique case ({a, b})
      2'b00: begin q = c ^ d;    r = c & ~d;  s = c | d;   end
      2'b01: begin q = ~(c ^ d); r = c | d;   s = c & ~d;  end
      2'b10: begin q = ~d;       r = c ^ d;   s = ~c;      end
      default: begin q = d;      r = ~c;      s = c ^ d;   end
    endcase
    t = d ^ e ^ (a & c);
    y_o = {p, q, r, s, t};

    // R5: total parity survives the gate
    assert_parity_kept_R5: assert ((^y_o) == (^x_i))
      else $error("gate parity broken for %b", x_i);
    // R6: NOR behaviour of the second output
    if (b && !d) begin
      assert_nor_form_R6: assert (q == ~(a | c))
        else $error("gate NOR form broken for %b", x_i);
    end
  end
endmodule

// File: rtl/ctl_swap3.sv
module ctl_swap3
  import rev_cell_pkg::*;
(
  input  logic ctl_i,
  input  logic u_i,
  input  logic v_i,
  output logic ctl_o,
  output logic u_o,
  output logic v_o
);
  always_comb begin
    ctl_o = ctl_i;
    if (ctl_i) begin
      u_o = v_i;
      v_o = u_i;
    end else begin
      u_o = u_i;
      v_o = v_i;
    end
    // R8: the swap only permutes its data lines, weight is kept
    assert_swap_weight_R8: assert ($countones({u_o, v_o}) == $countones({u_i, v_i}))
      else $error("swap changed weight");
  end
endmodule

// File: rtl/parity_watch.sv
module parity_watch
  import rev_cell_pkg::*;
(
  input  gate_vec_t gate_in_i,
  input  gate_vec_t gate_out_i,
  input  swap_vec_t swap_in_i,
  input  swap_vec_t swap_out_i,
  output logic      mismatch_o
);
  logic in_par, out_par;

  always_comb begin
    in_par     = (^gate_in_i) ^ (^swap_in_i);
    out_par    = (^gate_out_i) ^ (^swap_out_i);
    mismatch_o = in_par ^ out_par;
  end
endmodule

// File: rtl/rev_addsub_cell.sv
module rev_addsub_cell
  import rev_cell_pkg::*;
#(
  parameter bit ANCILLA_E = 1'b0
) (
  input  logic              mode_sub,
  input  logic              a_in,
  input  logic              b_in,
  input  logic              c_in,
  output logic              res_o,
  output logic              cb_o,
  output logic [GARB_W-1:0] garbage_o,
  output logic              fault_o
);
  localparam logic TIE_LOW = 1'b0;

  gate_vec_t g_in, g_out;
  logic      sw_ctl, sw_spare;

  // Operand order: b on the first line so the fourth output yields a - b - cin
  assign g_in = {b_in, a_in, TIE_LOW, c_in, ANCILLA_E};

  pp5_gate u_gate (
    .x_i (g_in),
    .y_o (g_out)
  );

  // Second output: sum, third: carry, fourth: borrow
  ctl_swap3 u_swap (
    .ctl_i (mode_sub),
    .u_i   (g_out[L_THIRD]),
    .v_i   (g_out[L_FOURTH]),
    .ctl_o (sw_ctl),
    .u_o   (cb_o),
    .v_o   (sw_spare)
  );

  assign res_o     = g_out[L_SECOND];
  assign garbage_o = {sw_ctl, sw_spare, g_out[L_FIRST], g_out[L_FIFTH]};

  parity_watch u_watch (
    .gate_in_i  (g_in),
    .gate_out_i (g_out),
    .swap_in_i  ({mode_sub, g_out[L_THIRD], g_out[L_FOURTH]}),
    .swap_out_i ({sw_ctl, cb_o, sw_spare}),
    .mismatch_o (fault_o)
  );

  always_comb begin
    assert_no_fault_R7: assert (fault_o == 1'b0)
      else $error("parity fault flagged");
    assert_result_bit_R3: assert (res_o == (a_in ^ b_in ^ c_in))
      else $error("result bit wrong");
    assert_mode_passthru_R8: assert (garbage_o[GARB_W-1] == mode_sub)
      else $error("mode not passed through");
  end
endmodule

// File: tb/rev_addsub_cell_bench.sv
module rev_addsub_cell_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_errs   = 0;

  logic       mode_sub, a_in, b_in, c_in;
  logic       res0, cb0, flt0, res1, cb1, flt1;
  logic [3:0] garb0, garb1;
  logic [4:0] g_x, g_y;

  rev_addsub_cell #(.ANCILLA_E(1'b0)) u_rev_addsub_cell (
    .mode_sub(mode_sub), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .res_o(res0), .cb_o(cb0), .garbage_o(garb0), .fault_o(flt0));

  rev_addsub_cell #(.ANCILLA_E(1'b1)) u_cell_e1 (
    .mode_sub(mode_sub), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .res_o(res1), .cb_o(cb1), .garbage_o(garb1), .fault_o(flt1));

  pp5_gate u_gate (.x_i(g_x), .y_o(g_y));

  // Output columns of the gate, entry 0 in the MSB
  localparam logic [31:0] COL_Q = 32'b0011_1100_1100_0011_1100_1100_0011_0011;
  localparam logic [31:0] COL_R = 32'b0000_1100_0011_1111_0011_1100_1111_0000;
  localparam logic [31:0] COL_S = 32'b0011_1111_0000_1100_1111_0000_0011_1100;
  localparam logic [31:0] COL_T = 32'b0110_0110_0110_0110_0110_1001_0110_1001;

  // {mode, a, b, cin, res, cb}
  localparam logic [5:0] VEC [16] = '{
    6'b0_000_00, 6'b0_001_10, 6'b0_010_10, 6'b0_011_01,
    6'b0_100_10, 6'b0_101_01, 6'b0_110_01, 6'b0_111_11,
    6'b1_000_00, 6'b1_001_11, 6'b1_010_11, 6'b1_011_01,
    6'b1_100_10, 6'b1_101_00, 6'b1_110_00, 6'b1_111_11};

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic drive(input logic m, input logic a, input logic b, input logic c);
    @(posedge clk);
    mode_sub = m; a_in = a; b_in = b; c_in = c;
    @(negedge clk);
  endtask

  function automatic logic ref_carry(input logic a, input logic b, input logic c);
    return ((a ^ b) & c) ^ (a & b);
  endfunction

  function automatic logic ref_borrow(input logic a, input logic b, input logic c);
    return (~a & b) ^ (~(a ^ b) & c);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] seen;
    mode_sub = 0; a_in = 0; b_in = 0; c_in = 0; g_x = '0;
    @(negedge clk);
    // Idle state with all inputs low (R3, R7)
    check("R3 idle res", {7'd0, res0}, 8'd0);
    check("R7 idle fault", {7'd0, flt0}, 8'd0);

    // Exhaustive gate sweep (R4, R5)
    seen = '0;
    for (int i = 0; i < 32; i++) begin
      logic [4:0] exp_y;
      @(posedge clk);
      g_x = 5'(i);
      @(negedge clk);
      exp_y = {g_x[4], COL_Q[31-i], COL_R[31-i], COL_S[31-i], COL_T[31-i]};
      check("R4 gate map", {3'd0, g_y}, {3'd0, exp_y});
      check("R5 gate parity", {7'd0, ^g_y}, {7'd0, ^g_x});
      seen[g_y] = 1'b1;
    end
    check("R4 bijective", {7'd0, &seen}, 8'd1);
    @(posedge clk); g_x = 5'b00010; @(negedge clk);
    check("R4 example 00010", {3'd0, g_y}, 8'b0000_1011);

    // NOR form (R6)
    for (int k = 0; k < 8; k++) begin
      logic [2:0] kk;
      kk = 3'(k);
      @(posedge clk);
      g_x = {kk[2], 1'b1, kk[1], 1'b0, kk[0]};
      @(negedge clk);
      check("R6 nor", {7'd0, g_y[3]}, {7'd0, ~(kk[2] | kk[1])});
    end

    // Table walk (R1, R2, R3, R7, R8, R9)
    for (int v = 0; v < 16; v++) begin
      logic [5:0] e;
      logic ec, eb;
      e = VEC[v];
      drive(e[5], e[4], e[3], e[2]);
      ec = ref_carry(e[4], e[3], e[2]);
      eb = ref_borrow(e[4], e[3], e[2]);
      check("R3 res", {7'd0, res0}, {7'd0, e[1]});
      if (e[5]) check("R2 borrow", {7'd0, cb0}, {7'd0, e[0]});
      else      check("R1 carry", {7'd0, cb0}, {7'd0, e[0]});
      check("R1 R2 formula", {7'd0, cb0}, {7'd0, e[5] ? eb : ec});
      check("R7 fault", {7'd0, flt0}, 8'd0);
      check("R8 garbage", {4'd0, garb0}, {4'd0, e[5], (e[5] ? ec : eb), e[3], e[2]});
      check("R9 res e1", {7'd0, res1}, {7'd0, e[1]});
      check("R9 cb e1", {7'd0, cb1}, {7'd0, e[0]});
      check("R9 fault e1", {7'd0, flt1}, 8'd0);
      check("R8 garbage e1", {7'd0, garb1[0]}, {7'd0, ~e[2]});
    end

    // Directed: same operands, mode flips; carry and borrow differ here
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    check("R1 0+1 carry", {7'd0, cb0}, 8'd0);
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    check("R2 0-1 borrow", {7'd0, cb0}, 8'd1);
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    check("R2 1-0-1 borrow", {7'd0, cb0}, 8'd0);
    check("R3 1-0-1 diff", {7'd0, res0}, 8'd0);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule